// File: doc/BRIEF.md
# Shift-Register FIFO with Counter-Addressed Read Tap

This block is a single-clock first-in first-out buffer whose storage is a chain of shift registers, one per data bit, all advancing together. Every accepted write enters at tap zero and pushes older words one tap further along. There are no read or write pointers. A single up-down occupancy counter does all the bookkeeping, and its low bits select the tap that drives the read data. Because the oldest word always sits at the tap the counter names, the read port shows the head of the queue with no prior pop.

The counter is one bit wider than the tap address and is loaded with all ones at reset. Its top bit is therefore the empty flag at no cost. The first accepted write rolls the counter over to zero, which points at tap zero, where that word now sits. A pop does not move any data. It only lowers the counter, so the read tap moves one step toward the entry point. Depth (a power of two, 16 by default) and word width are parameters.

Top module: `shift_fifo`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `empty` is 1 and `full` is 0, and the FIFO holds no entries.
- R2: A push (`push`=1) on a FIFO that is not full stores `wr_data` at tap zero, moves every held word one tap deeper, and raises the occupancy by one.
- R3: A pop (`pop`=1) on a non-empty FIFO leaves stored data in place and lowers the occupancy by one, so the next-oldest word appears on `rd_data` in the following cycle.
- R4: While `empty` is 0, `rd_data` combinationally shows the oldest held word.
- R5: `empty` is the most significant bit of the occupancy counter. The counter holds all ones with no entries and the value n-1 with n entries (1 to DEPTH).
- R6: `full` is 1 exactly when DEPTH entries are held (counter equal to DEPTH-1), and `empty` and `full` are never both 1.
- R7: Push and pop together on a FIFO that is neither empty nor full keep the occupancy unchanged, add the new word at the tail and present the next-oldest word on `rd_data`.
- R8: A push while full is ignored: no word is stored and the counter does not rise. With push and pop together while full, only the pop takes effect.
- R9: A pop while empty is ignored: the FIFO stays empty, and a later push is read back correctly.
- R10: A push into an empty FIFO rolls the counter from all ones to zero, clears `empty`, and the word is readable on `rd_data` in the next cycle.
- R11: All WIDTH bit lanes share one counter and behave identically, so every bit of a word is returned unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store on an accepted push |
| pop | input | 1 | Read-release request |
| rd_data | output | WIDTH | Oldest held word, valid while empty is 0 |
| empty | output | 1 | No entries held |
| full | output | 1 | DEPTH entries held |

## Verification
The assertions assume that `push` and `pop` are settled well before each rising edge and that `rd_data` is only meaningful while `empty` is low; they make no assumption that requests respect the flags, since overflow and underflow requests must be dropped by the block itself. The stimulus therefore deliberately pushes into a full FIFO, pops an empty one and issues both requests together at each occupancy extreme, then runs a long stretch of random requests so the counter crosses its wrap point many times. Inputs are changed only at falling edges and outputs are compared there against a behavioural queue.

// File: rtl/shift_fifo_pkg.sv
package shift_fifo_pkg;

   typedef enum logic [1:0] {
      SF_IDLE = 2'b00,
      SF_PUSH = 2'b01,
      SF_POP  = 2'b10,
      SF_BOTH = 2'b11
   } sf_op_e;

   function automatic int sf_addr_bits(input int depth);
      return $clog2(depth);
   endfunction

endpackage

// File: rtl/shift_fifo_ctrl.sv
module shift_fifo_ctrl
   import shift_fifo_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int AW = sf_addr_bits(DEPTH),
   localparam int CW = AW + 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push,
   input  logic          pop,
   output logic          shift_en,
   output logic [AW-1:0] rd_addr,
   output logic          empty,
   output logic          full
);

   logic [CW-1:0] occ_q;
   logic          take_push;
   logic          take_pop;
   sf_op_e        op;

   assign empty     = occ_q[CW-1];
   assign full      = (occ_q == CW'(DEPTH - 1));
   assign take_push = push & ~full;
   assign take_pop  = pop & ~empty;
   assign op        = sf_op_e'({take_pop, take_push});
   assign shift_en  = take_push;
   assign rd_addr   = occ_q[AW-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         occ_q <= '1;
      end else begin
         unique case (op)
            SF_PUSH: occ_q <= occ_q + 1'b1;
            SF_POP:  occ_q <= occ_q - 1'b1;
            default: occ_q <= occ_q;
         endcase
      end
   end

   assert_reset_empty_R1: assert property (@(posedge clk)
      $past(rst) |-> (empty && !full));

   assert_count_up_R2: assert property (@(posedge clk) disable iff (rst)
      (push && !pop && !full) |=> (occ_q == $past(occ_q) + 1'b1));

   assert_count_down_R3: assert property (@(posedge clk) disable iff (rst)
      (pop && !push && !empty) |=> (occ_q == $past(occ_q) - 1'b1));

   assert_flags_excl_R6: assert property (@(posedge clk) disable iff (rst)
      !(empty && full));

   assert_both_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (push && pop && !empty && !full) |=> $stable(occ_q));

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
      (full && push && !pop) |=> (full && $stable(occ_q)));

   assert_no_underflow_R9: assert property (@(posedge clk) disable iff (rst)
      (empty && pop && !push) |=> (empty && $stable(occ_q)));

   assert_first_word_R10: assert property (@(posedge clk) disable iff (rst)
      (empty && push) |=> (!empty && occ_q == '0));

endmodule

// File: rtl/shift_fifo_lane.sv
module shift_fifo_lane #(
   parameter int DEPTH = 16,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          shift_en,
   input  logic          din,
   input  logic [AW-1:0] addr,
   output logic          dout
);

   logic [DEPTH-1:0] taps_q;

   always_ff @(posedge clk) begin
      if (shift_en) begin
         taps_q <= {taps_q[DEPTH-2:0], din};
      end
   end

   assign dout = taps_q[addr];

   assert_tap0_load_R2: assert property (@(posedge clk) disable iff (rst)
      shift_en |=> (taps_q[0] == $past(din)));

   assert_taps_hold_R3: assert property (@(posedge clk) disable iff (rst)
      !shift_en |=> $stable(taps_q));

endmodule

// File: rtl/shift_fifo.sv
module shift_fifo
   import shift_fifo_pkg::*;
#(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16,
   localparam int AW = sf_addr_bits(DEPTH)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             push,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             pop,
   output logic [WIDTH-1:0] rd_data,
   output logic             empty,
   output logic             full
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("shift_fifo: DEPTH must be a power of two of at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("shift_fifo: WIDTH must be at least 1");
   end

   logic          shift_en;
   logic [AW-1:0] rd_addr;

   shift_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .push     (push),
      .pop      (pop),
      .shift_en (shift_en),
      .rd_addr  (rd_addr),
      .empty    (empty),
      .full     (full)
   );

   for (genvar b = 0; b < WIDTH; b++) begin : g_lane
      shift_fifo_lane #(.DEPTH(DEPTH)) u_lane (
         .clk      (clk),
         .rst      (rst),
         .shift_en (shift_en),
         .din      (wr_data[b]),
         .addr     (rd_addr),
         .dout     (rd_data[b])
      );
   end

   assert_head_stable_R4: assert property (@(posedge clk) disable iff (rst)
      (!push && !pop && !empty) |=> $stable(rd_data));

endmodule

// File: tb/shift_fifo_bench.sv
module shift_fifo_bench;
   localparam int W = 8;
   localparam int D = 16;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         push = 1'b0;
   logic         pop = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] rd_data;
   logic         empty;
   logic         full;

   int n_checks = 0;
   int n_fail = 0;
   bit model_on = 1'b0;
   bit done = 1'b0;

   logic [W-1:0] mq[$];

   always #10 clk = ~clk;

   shift_fifo #(.WIDTH(W), .DEPTH(D)) u_shift_fifo (
      .clk(clk), .rst(rst), .push(push), .wr_data(wr_data),
      .pop(pop), .rd_data(rd_data), .empty(empty), .full(full)
   );

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // reference queue, updated at the same edge as the design
   always @(posedge clk) begin
      if (rst) begin
         mq.delete();
      end else begin
         bit tp;
         bit tq;
         tp = push && (mq.size() < D);
         tq = pop && (mq.size() > 0);
         if (tq) void'(mq.pop_front());
         if (tp) mq.push_back(wr_data);
      end
   end

   // per-cycle comparison at the falling edge
   always @(negedge clk) begin
      if (model_on && !rst) begin
         chk("R5 empty vs model", W'(empty), W'(mq.size() == 0));
         chk("R6 full vs model", W'(full), W'(mq.size() == D));
         if (mq.size() > 0) chk("R4 head vs model", rd_data, mq[0]);
      end
   end

   task automatic step(input logic p, input logic q, input logic [W-1:0] d);
      push = p; pop = q; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      push = 1'b0; pop = 1'b0;
   endtask

   initial begin
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      model_on = 1'b1;
      chk("R1 empty after reset", W'(empty), W'(1));
      chk("R1 full after reset", W'(full), W'(0));

      step(1, 0, 8'h3C);
      chk("R10 empty cleared", W'(empty), W'(0));
      chk("R10 first word", rd_data, 8'h3C);
      step(1, 0, 8'h81);
      step(1, 0, 8'h7E);
      chk("R4 oldest shown", rd_data, 8'h3C);
      chk("R2 not empty after pushes", W'(empty), W'(0));
      step(0, 1, 8'h00);
      chk("R3 pop reveals next", rd_data, 8'h81);
      step(1, 1, 8'h42);
      chk("R7 push+pop head", rd_data, 8'h7E);
      step(0, 1, 8'h00);
      chk("R7 new word at tail", rd_data, 8'h42);
      step(0, 1, 8'h00);
      chk("R5 empty after drain", W'(empty), W'(1));
      step(0, 1, 8'h00);
      chk("R9 pop while empty", W'(empty), W'(1));
      chk("R9 not full", W'(full), W'(0));
      step(1, 0, 8'h99);
      chk("R9 push after underflow try", rd_data, 8'h99);
      step(0, 1, 8'h00);

      for (int i = 0; i < D; i++) begin
         step(1, 0, W'(i * 17));
         if (i == D - 2) chk("R6 not full at D-1", W'(full), W'(0));
      end
      chk("R6 full at D", W'(full), W'(1));
      chk("R11 all-zero word head", rd_data, 8'h00);
      step(1, 0, 8'hEE);
      chk("R8 still full", W'(full), W'(1));
      chk("R8 head unchanged", rd_data, 8'h00);
      step(1, 1, 8'hCC);
      chk("R8 both while full pops only", W'(full), W'(0));
      chk("R8 head after pop", rd_data, 8'h11);
      for (int i = 2; i < D; i++) begin
         step(0, 1, 8'h00);
         chk("R11 word lanes intact", rd_data, W'(i * 17));
      end
      step(0, 1, 8'h00);
      chk("R8 dropped words absent", W'(empty), W'(1));

      for (int i = 0; i < 3000; i++) begin
         int r;
         r = int'($urandom_range(0, 99));
         step(r < 55, (r % 3) == 0 || r > 80, W'($urandom));
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule